// File: doc/BRIEF.md
# Square Pixel Fill Engine

This block is a register-mapped drawing engine for a display of 250 rows by 250 columns. A processor programs four byte registers: the top-left row, the top-left column, the side length and the colour. Writing the colour register starts a command. The engine then paints a filled square by sending one pixel per accepted beat on a framebuffer write stream.

Before any drawing starts, the engine checks the command. A start coordinate outside the display, or a side length outside 1 to 16, is refused. The refusal sets a sticky error flag, and no pixel is sent. A square that begins on the display but runs past its lower or right edge is trimmed. Only the part that lies on the display is sent, and the trimmed part takes no cycles.

The pixel stream uses valid/ready handshaking. The engine raises `fb_valid` with a pixel and keeps that pixel and `fb_valid` unchanged until `fb_ready` is sampled high at a clock edge. When `fb_ready` stays high, one pixel is sent on every clock. The status register can be read at any time and shows whether a fill is running and whether a command has been refused.

Top module: `sqfill_engine`

## Requirements
- R1: The registers are read back combinationally on `reg_rdata`, selected by `reg_rd_addr`. Offset 0 is the row, 1 the column, 2 the colour and 3 the side length. Offset 4 is status: bit 0 is busy, bit 1 is the error flag, and the other bits read 0. Offsets 5 to 7 read 0.
- R2: A write to offset 2 while idle stores the colour and starts a command. The command uses the row, column and side length held at that moment, together with the written colour.
- R3: The square is sent in row-major order. The column runs fastest, from the start column upward, and the row advances by one after each line. Every pixel carries the command's colour.
- R4: Pixels whose row or column would be above 249 are not sent and take no cycles. The rest of the square is still sent.
- R5: A side length of 0 or above 16, or a start row or column above 249, sets status bit 1 and sends no pixel. The flag stays set until reset, even across later valid commands.
- R6: Status bit 0 goes high in the cycle after an accepted start. It goes low in the cycle after the last pixel's handshake.
- R7: While busy, writes to any register are ignored. They neither change the readable values nor start a command.
- R8: While `fb_valid` is high and `fb_ready` is low, `fb_valid`, `fb_row`, `fb_col` and `fb_color` hold their values at the next edge.
- R9: After reset all registers and status read 0 and `fb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write offset |
| reg_wdata | input | 8 | Write data |
| reg_rd_addr | input | 3 | Read offset |
| reg_rdata | output | 8 | Read data, combinational |
| fb_valid | output | 1 | Pixel write available |
| fb_ready | input | 1 | Framebuffer accepts the pixel |
| fb_row | output | 8 | Pixel row |
| fb_col | output | 8 | Pixel column |
| fb_color | output | 8 | Pixel colour |

## Verification
The assertions take the following for granted about the inputs:
- At most one register write arrives per cycle.
- `fb_ready` is a clean level sampled only at clock edges.
- No input changes in the middle of a cycle.

The bench drives every input at the falling edge, issues writes one cycle at a time, and switches `fb_ready` only between edges. The back-pressure patterns are fixed and include long stalls, so the hold property in R8 is exercised while that rule is respected.

// File: rtl/sqfill_pkg.sv
package sqfill_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam logic [AW-1:0] OFF_ROW    = 3'd0;
  localparam logic [AW-1:0] OFF_COL    = 3'd1;
  localparam logic [AW-1:0] OFF_COLOR  = 3'd2;
  localparam logic [AW-1:0] OFF_SIZE   = 3'd3;
  localparam logic [AW-1:0] OFF_STATUS = 3'd4;

  typedef struct packed {
    logic [DW-1:0] row;
    logic [DW-1:0] col;
    logic [DW-1:0] color;
    logic [DW-1:0] size;
  } cmd_regs_t;
endpackage

// File: rtl/sqfill_regs.sv
module sqfill_regs
  import sqfill_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic          busy,
  input  logic          err,
  output cmd_regs_t     regs,
  output logic          start,
  output logic [DW-1:0] rdata
);
  logic wr_ok;
  assign wr_ok = wr && !busy;
  assign start = wr_ok && (waddr == OFF_COLOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_ok) begin
      case (waddr)
        OFF_ROW:   regs.row   <= wdata;
        OFF_COL:   regs.col   <= wdata;
        OFF_COLOR: regs.color <= wdata;
        OFF_SIZE:  regs.size  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (raddr)
      OFF_ROW:    rdata = regs.row;
      OFF_COL:    rdata = regs.col;
      OFF_COLOR:  rdata = regs.color;
      OFF_SIZE:   rdata = regs.size;
      OFF_STATUS: rdata = {{(DW-2){1'b0}}, err, busy};
      default:    rdata = '0;
    endcase
  end

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(regs)); // R7
endmodule

// File: rtl/sqfill_bounds.sv
module sqfill_bounds
  import sqfill_pkg::*;
#(
  parameter int ROWS     = 250,
  parameter int COLS     = 250,
  parameter int MAX_SIZE = 16,
  localparam int SW      = $clog2(MAX_SIZE + 1)
)(
  input  logic [DW-1:0] row,
  input  logic [DW-1:0] col,
  input  logic [DW-1:0] size,
  output logic          bad,
  output logic [SW-1:0] width,
  output logic [SW-1:0] height
);
  logic [DW:0] room_c, room_r;
  logic        bad_r, bad_c, bad_s;

  always_comb begin
    bad_r  = ({1'b0, row} >= (DW+1)'(ROWS));
    bad_c  = ({1'b0, col} >= (DW+1)'(COLS));
    bad_s  = (size == '0) || ({1'b0, size} > (DW+1)'(MAX_SIZE));
    bad    = bad_r || bad_c || bad_s;
    room_c = (DW+1)'(COLS) - {1'b0, col};
    room_r = (DW+1)'(ROWS) - {1'b0, row};
    width  = ({1'b0, size} < room_c) ? size[SW-1:0] : room_c[SW-1:0];
    height = ({1'b0, size} < room_r) ? size[SW-1:0] : room_r[SW-1:0];
  end
endmodule

// File: rtl/sqfill_seq.sv
module sqfill_seq
  import sqfill_pkg::*;
#(
  parameter int ROWS     = 250,
  parameter int COLS     = 250,
  parameter int MAX_SIZE = 16,
  localparam int SW      = $clog2(MAX_SIZE + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] base_row,
  input  logic [DW-1:0] base_col,
  input  logic [DW-1:0] color,
  input  logic [SW-1:0] width,
  input  logic [SW-1:0] height,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_row,
  output logic [DW-1:0] out_col,
  output logic [DW-1:0] out_color
);
  logic [DW-1:0] row0_q, col0_q, color_q;
  logic [SW-1:0] w_q, h_q, r_off, c_off;
  logic          line_end, last, fire;

  assign line_end  = (c_off == w_q - SW'(1));
  assign last      = line_end && (r_off == h_q - SW'(1));
  assign fire      = busy && out_ready;
  assign out_valid = busy;
  assign out_row   = row0_q + DW'(r_off);
  assign out_col   = col0_q + DW'(c_off);
  assign out_color = color_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      row0_q  <= '0;
      col0_q  <= '0;
      color_q <= '0;
      w_q     <= '0;
      h_q     <= '0;
      r_off   <= '0;
      c_off   <= '0;
    end else if (load && !busy) begin
      busy    <= 1'b1;
      row0_q  <= base_row;
      col0_q  <= base_col;
      color_q <= color;
      w_q     <= width;
      h_q     <= height;
      r_off   <= '0;
      c_off   <= '0;
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
      end else if (line_end) begin
        c_off <= '0;
        r_off <= r_off + SW'(1);
      end else begin
        c_off <= c_off + SW'(1);
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row)
      && $stable(out_col) && $stable(out_color)); // R8
  AST_IN_DISPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_row) < ROWS) && (int'(out_col) < COLS)); // R4
  AST_ROW_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !last |=> out_valid &&
      ((out_row == $past(out_row) && out_col == $past(out_col) + 8'd1) ||
       (out_row == $past(out_row) + 8'd1 && out_col == col0_q))); // R3
endmodule

// File: rtl/sqfill_engine.sv
module sqfill_engine
  import sqfill_pkg::*;
#(
  parameter int ROWS     = 250,
  parameter int COLS     = 250,
  parameter int MAX_SIZE = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic [2:0]    reg_rd_addr,
  output logic [7:0]    reg_rdata,
  output logic          fb_valid,
  input  logic          fb_ready,
  output logic [7:0]    fb_row,
  output logic [7:0]    fb_col,
  output logic [7:0]    fb_color
);
  localparam int SW = $clog2(MAX_SIZE + 1);

  cmd_regs_t     regs;
  logic          start, busy, bad, err;
  logic [SW-1:0] width, height;

  sqfill_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_addr),
    .wdata(reg_wdata), .raddr(reg_rd_addr), .busy(busy), .err(err),
    .regs(regs), .start(start), .rdata(reg_rdata)
  );

  sqfill_bounds #(.ROWS(ROWS), .COLS(COLS), .MAX_SIZE(MAX_SIZE)) u_bounds (
    .row(regs.row), .col(regs.col), .size(regs.size),
    .bad(bad), .width(width), .height(height)
  );

  sqfill_seq #(.ROWS(ROWS), .COLS(COLS), .MAX_SIZE(MAX_SIZE)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(start && !bad),
    .base_row(regs.row), .base_col(regs.col), .color(reg_wdata),
    .width(width), .height(height), .busy(busy),
    .out_valid(fb_valid), .out_ready(fb_ready),
    .out_row(fb_row), .out_col(fb_col), .out_color(fb_color)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             err <= 1'b0;
    else if (start && bad)  err <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R5
  AST_REFUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    start && bad |=> !fb_valid); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !bad |=> fb_valid && reg_rd_addr != 3'd4 || reg_rdata[0]); // R6
endmodule

// File: tb/test_sqfill_engine.sv
module test_sqfill_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] reg_rd_addr = '0;
  logic [7:0] reg_rdata;
  logic       fb_valid;
  logic       fb_ready = 1'b1;
  logic [7:0] fb_row, fb_col, fb_color;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  bit done   = 0;

  int m_row = 0, m_col = 0, m_color = 0, m_size = 0, m_err = 0;
  int q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sqfill_engine i_sqfill_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .fb_valid(fb_valid), .fb_ready(fb_ready), .fb_row(fb_row),
    .fb_col(fb_col), .fb_color(fb_color)
  );

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, got, exp, cycle);
    end
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return m_row;
      1: return m_col;
      2: return m_color;
      3: return m_size;
      4: return (m_err << 1) | (q.size() != 0 ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  // Behavioural model of one rising edge
  task automatic model_edge();
    bit was_busy;
    was_busy = (q.size() != 0);
    if (was_busy && fb_ready) void'(q.pop_front());
    if (reg_wr && !was_busy) begin
      case (int'(reg_addr))
        0: m_row = reg_wdata;
        1: m_col = reg_wdata;
        3: m_size = reg_wdata;
        2: begin
          m_color = reg_wdata;
          if (m_size == 0 || m_size > 16 || m_row > 249 || m_col > 249)
            m_err = 1;
          else
            for (int r = 0; r < m_size; r++)
              for (int c = 0; c < m_size; c++)
                if (m_row + r <= 249 && m_col + c <= 249)
                  q.push_back(((m_row + r) << 16) | ((m_col + c) << 8) | m_color);
        end
        default: ;
      endcase
    end
  endtask

  task automatic cyc();
    reg_rd_addr = 3'(cycle % 8);
    #1;
    check("R1", "rdata", reg_rdata, model_read(cycle % 8));
    check("R6", "busy vs valid", fb_valid, q.size() != 0);
    if (fb_valid && q.size() != 0) begin
      check("R3", "row", fb_row, (q[0] >> 16) & 255);
      check("R3", "col", fb_col, (q[0] >> 8) & 255);
      check("R2", "color", fb_color, q[0] & 255);
    end
    model_edge();
    @(posedge clk);
    @(negedge clk);
    cycle++;
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic cmd(int r, int c, int s, int col);
    wr(0, r); wr(1, c); wr(3, s); wr(2, col);
  endtask

  task automatic drain();
    while (q.size() != 0) cyc();
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    for (int a = 0; a < 8; a++) begin
      reg_rd_addr = 3'(a);
      #1;
      check("R9", "reset read", reg_rdata, 0);
    end
    check("R9", "reset valid", fb_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: plain 3x3 square
    cmd(10, 20, 3, 8'h5A);
    drain();
    // single pixel in the far corner
    cmd(249, 249, 1, 8'h11);
    drain();
    // R4: clipped on both edges, 3 rows x 5 cols
    cmd(247, 245, 8, 8'h33);
    drain();
    // full 16x16
    cmd(0, 0, 16, 8'hC3);
    drain();
    // R8: back-pressure pattern
    cmd(100, 50, 4, 8'h77);
    for (int i = 0; i < 60 && (q.size() != 0 || i < 2); i++) begin
      fb_ready = ((i % 3) != 1) && ((i % 11) < 8);
      cyc();
    end
    fb_ready = 1'b1;
    drain();
    // R7: writes while busy are ignored
    cmd(30, 30, 5, 8'h44);
    wr(0, 99); wr(1, 98); wr(3, 2); wr(2, 8'hEE);
    drain();
    check("R7", "row kept", m_row, 30);
    // R5: refused commands, sticky flag
    cmd(10, 10, 0, 8'h01);
    drain();
    check("R5", "flag set", m_err, 1);
    cmd(10, 10, 17, 8'h02);
    drain();
    cmd(250, 0, 2, 8'h03);
    drain();
    cmd(0, 250, 2, 8'h04);
    drain();
    // valid command after an error still draws, flag stays
    cmd(5, 6, 2, 8'h99);
    drain();
    repeat (8) cyc();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule